// File: doc/BRIEF.md
# Add/Subtract Unit with Overflow Classification

This block adds or subtracts two two's complement operands of a configurable width (four bits by default) and returns the wrapped result. It also returns two separate out-of-range flags. One flag marks a true result above the largest positive value. The other marks a true result below the most negative value.

Subtraction reuses the adder. The second operand is inverted and a carry of one enters the least significant stage of a ripple chain. The carry entering the top stage is compared with the carry leaving it, and a mismatch means the true result does not fit. The sign bit of the wrapped result then tells which way it left the range: a negative-looking result means positive overflow, and a positive-looking one means negative underflow.

The block is purely combinational, with no clock, no state and no handshake. The outputs follow the inputs within the same evaluation. It suits use as a datapath element inside a larger pipeline.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (A + B) modulo 2^W. For W = 4, 1101 + 1111 gives 1100.
- R2: With `sub_mode` = 1, `result` equals (A - B) modulo 2^W. For W = 4, 1101 - 1111 gives 1110.
- R3: `ovf_pos` is 1 exactly when the true signed result exceeds 2^(W-1)-1. Examples: 0110 + 0100 and 0111 - 1010.
- R4: `ovf_neg` is 1 exactly when the true signed result is below -2^(W-1). Examples: 1000 + 1111, 1101 - 0111 and 1000 - 0001.
- R5: `ovf_pos` and `ovf_neg` are never both 1, and both are 0 for an in-range result. Examples: 0111 + 1010 = 0001, 1111 + 1111 = 1110, and all-zero inputs giving 0000.
- R6: Subtracting the most negative value from a non-negative operand is flagged as positive overflow. For W = 4, 0000 - 1000 gives 1000 with `ovf_pos` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand, two's complement |
| opnd_b | input | W | Second operand, two's complement |
| sub_mode | input | 1 | 0 selects A + B, 1 selects A - B |
| result | output | W | Wrapped sum or difference |
| ovf_pos | output | 1 | True result above the positive limit |
| ovf_neg | output | 1 | True result below the negative limit |

## Verification
The bench builds the unit at the default width of four. At that width every operand pair in both modes can be covered: 512 combinations in all, including every carry pattern into and out of the sign stage. A seeded random pass and directed cases sit on top of this sweep. The directed cases cover the subtract-most-negative corner and the examples named in the requirements.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } addsub_mode_e;
endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] raw_b,
  input  logic         mode,
  output logic [W-1:0] eff_b,
  output logic         carry_seed
);
  logic is_sub;

  always_comb begin
    is_sub     = (addsub_mode_e'(mode) == MODE_SUB);
    eff_b      = is_sub ? ~raw_b : raw_b;
    carry_seed = is_sub;
  end
endmodule

// File: rtl/addsub_fa.sv
module addsub_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_top_in,
  output logic         c_top_out
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    addsub_fa u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign c_top_in  = chain[W-1];
  assign c_top_out = chain[W];
endmodule

// File: rtl/addsub_range_class.sv
module addsub_range_class (
  input  logic c_top_in,
  input  logic c_top_out,
  input  logic sum_sign,
  output logic hi_flag,
  output logic lo_flag
);
  logic out_of_range;

  always_comb begin
    out_of_range = c_top_in ^ c_top_out;
    hi_flag      = out_of_range & sum_sign;
    lo_flag      = out_of_range & ~sum_sign;
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         sub_mode,
  output logic [W-1:0] result,
  output logic         ovf_pos,
  output logic         ovf_neg
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         cin;
  logic         c_in_msb;
  logic         c_out_msb;

  addsub_operand_cond #(.W(W)) u_cond (
    .raw_b      (opnd_b),
    .mode       (sub_mode),
    .eff_b      (b_eff),
    .carry_seed (cin)
  );

  addsub_ripple #(.W(W)) u_chain (
    .x         (opnd_a),
    .y         (b_eff),
    .cin       (cin),
    .sum       (result),
    .c_top_in  (c_in_msb),
    .c_top_out (c_out_msb)
  );

  addsub_range_class u_class (
    .c_top_in  (c_in_msb),
    .c_top_out (c_out_msb),
    .sum_sign  (result[MSB]),
    .hi_flag   (ovf_pos),
    .lo_flag   (ovf_neg)
  );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         sub_mode,
  input logic [W-1:0] result,
  input logic         ovf_pos,
  input logic         ovf_neg
);
  localparam int M = W - 1;

  logic [W-1:0] wrap_add;
  logic [W-1:0] wrap_sub;

  always_comb begin
    wrap_add = opnd_a + opnd_b;
    wrap_sub = opnd_a - opnd_b;

    if (!sub_mode) begin
      p_sum_add_r1: assert (result == wrap_add);
    end
    if (sub_mode) begin
      p_sum_sub_r2: assert (result == wrap_sub);
    end

    // R3: positive overflow requires a non-negative A, an effective B that is
    // non-negative, and a result that looks negative.
    if (ovf_pos) begin
      p_no_overflow_r3: assert (!opnd_a[M] && (opnd_b[M] == sub_mode) && result[M]);
    end

    // R4: negative underflow requires a negative A, an effective B that is
    // negative, and a result that looks non-negative.
    if (ovf_neg) begin
      p_no_underflow_r4: assert (opnd_a[M] && (opnd_b[M] != sub_mode) && !result[M]);
    end

    p_flags_exclusive_r5: assert (!(ovf_pos && ovf_neg));
  end
endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) u_addsub_unit_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .sub_mode (sub_mode),
  .result   (result),
  .ovf_pos  (ovf_pos),
  .ovf_neg  (ovf_neg)
);

// File: tb/addsub_unit_bench.sv
module addsub_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int MAXP = (1 << (W - 1)) - 1;
  localparam int MINN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         mode;
  logic [W-1:0] res;
  logic         hi;
  logic         lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addsub_unit #(.W(W)) u_addsub_unit (
    .opnd_a   (a),
    .opnd_b   (b),
    .sub_mode (mode),
    .result   (res),
    .ovf_pos  (hi),
    .ovf_neg  (lo)
  );

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic int true_val(input logic [W-1:0] x, input logic [W-1:0] y, input logic m);
    return m ? sx(x) - sx(y) : sx(x) + sx(y);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (a=%b b=%b mode=%b)",
               req, what, act, exp, a, b, mode);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic m);
    int t;
    logic [W-1:0] exp_res;
    @(negedge clk);
    a = x; b = y; mode = m;
    #1;
    t = true_val(x, y, m);
    exp_res = W'(t);
    check(m ? "R2" : "R1", "result", int'(res), int'(exp_res));
    check("R3", "ovf_pos", int'(hi), (t > MAXP) ? 1 : 0);
    check("R4", "ovf_neg", int'(lo), (t < MINN) ? 1 : 0);
    if (hi && lo) check("R5", "both flags", 1, 0);
  endtask

  task automatic directed(input logic [W-1:0] x, input logic [W-1:0] y, input logic m,
                          input logic [W-1:0] er, input int eh, input int el, input string req);
    @(negedge clk);
    a = x; b = y; mode = m;
    #1;
    check(req, "directed result", int'(res), int'(er));
    check(req, "directed ovf_pos", int'(hi), eh);
    check(req, "directed ovf_neg", int'(lo), el);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed_init;
    a = '0; b = '0; mode = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R5: all-zero inputs give a zero result and no flags
    check("R5", "idle result", int'(res), 0);
    check("R5", "idle ovf_pos", int'(hi), 0);
    check("R5", "idle ovf_neg", int'(lo), 0);

    directed(4'b1101, 4'b1111, 1'b0, 4'b1100, 0, 0, "R1");
    directed(4'b1101, 4'b1111, 1'b1, 4'b1110, 0, 0, "R2");
    directed(4'b0110, 4'b0100, 1'b0, 4'b1010, 1, 0, "R3");
    directed(4'b0111, 4'b1010, 1'b1, 4'b1101, 1, 0, "R3");
    directed(4'b1000, 4'b1111, 1'b0, 4'b0111, 0, 1, "R4");
    directed(4'b1101, 4'b0111, 1'b1, 4'b0110, 0, 1, "R4");
    directed(4'b1000, 4'b0001, 1'b1, 4'b0111, 0, 1, "R4");
    directed(4'b0111, 4'b1010, 1'b0, 4'b0001, 0, 0, "R5");
    directed(4'b1111, 4'b1111, 1'b0, 4'b1110, 0, 0, "R5");
    directed(4'b0000, 4'b1000, 1'b1, 4'b1000, 1, 0, "R6");
    directed(4'b1000, 4'b1000, 1'b1, 4'b0000, 0, 0, "R6");

    for (int m = 0; m < 2; m++)
      for (int x = 0; x < (1 << W); x++)
        for (int y = 0; y < (1 << W); y++)
          apply(W'(x), W'(y), m[0]);

    seed_init = $urandom(32'd2024);
    for (int k = 0; k < 200; k++)
      apply(W'($urandom), W'($urandom), 1'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule